// File: doc/BRIEF.md
# Tiny 8-bit Multicycle Processor Core

This block is a compact 8-bit processor. It has four general registers and one 256-byte memory that holds both code and data. An instruction is a single opcode byte followed by zero, one or two operand bytes. The core reads these bytes one per clock from successive addresses, then spends one cycle executing. It performs register copy, add, subtract, OR, AND, XOR, compare, an unconditional jump, a jump taken only on equality, a byte output, a byte input and halt.

The memory is filled through a load port before the program runs. The usual sequence is to hold `rst_n` low, write the image byte by byte, then release reset. The core then starts fetching at address 0x00. Memory contents are not cleared by reset.

Output bytes leave as a one-cycle strobe with no back-pressure. Input bytes arrive over a valid/ready handshake. A byte transfers on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` stays high while the core waits, and the core stalls for as long as the input side withholds `in_valid`. When the core stops it reports this on `halted`, and `halt_code` holds the opcode that stopped it.

Top module: `tiny8_core`

## Requirements
- R1: While `rst_n` is low and after it is released, the core starts from a cleared state. `halted`, `halt_code`, `out_valid` and `in_ready` are 0, every register reads 0, the equality flag is clear and fetching begins at address 0x00.
- R2: Register-pair opcodes are copy 0xA0, add 0xB0, subtract 0xB1, OR 0xC0, AND 0xC1 and XOR 0xC2. Each is followed by a destination byte and then a source byte. The result of destination op source (or the source alone for copy) is written to the destination, with add and subtract wrapping modulo 256.
- R3: Only bits [1:0] of a register operand byte select the register. The other bits are ignored.
- R4: Jump 0xE0 takes one address byte and continues execution at that address.
- R5: Compare 0xE2 takes two register bytes and sets the equality flag when their values match. Jump-if-equal 0xE1 takes a register byte, which is ignored, and then an address byte. It jumps only when the flag is set and otherwise falls through.
- R6: The flag set by a compare is seen only by the instruction that immediately follows it. Any later instruction finds it clear. A no-op 0x00 counts as an instruction.
- R7: Output 0xD0 takes one register byte and presents that register's value on `out_data`, with `out_valid` high for exactly one cycle.
- R8: Input 0xD1 takes one register byte. The core holds `in_ready` high and waits until `in_valid` is high, then writes `in_data` into the register.
- R9: Halt 0xFF stops the core with `halt_code` = 0xFF. Once halted, the core fetches, outputs and accepts nothing more until reset.
- R10: Any opcode outside the set listed in R2 to R9 halts the core, and `halt_code` reports that opcode.
- R11: Each byte read advances the 8-bit program counter by one, and the counter wraps from 0xFF to 0x00, including inside an instruction's operands.
- R12: A write on the load port (`ld_en` high at a rising edge) stores `ld_data` at `ld_addr`. It works while reset is held, and memory keeps its contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Memory load write enable |
| ld_addr | input | 8 | Memory load address |
| ld_data | input | 8 | Memory load byte |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | One-cycle strobe qualifying `out_data` |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Core waiting to accept an input byte |
| halted | output | 1 | Core has stopped |
| halt_code | output | 8 | Opcode that caused the stop |

## Verification
The only internal state visible at the ports is what reaches the output strobe, the input handshake and the halt status. A wrong register value or a wrong ALU result therefore shows up a few cycles later, in the byte an output instruction emits. A program counter or operand-count error shows up as a misparsed stream: the wrong or missing output bytes, a halt on a stray opcode with a telltale `halt_code`, or no halt at all. A flag that lives too long or too briefly changes which branch runs, and so changes how many bytes come out.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;

  localparam logic [7:0] OP_NOP = 8'h00;
  localparam logic [7:0] OP_MOV = 8'hA0;
  localparam logic [7:0] OP_ADD = 8'hB0;
  localparam logic [7:0] OP_SUB = 8'hB1;
  localparam logic [7:0] OP_OR  = 8'hC0;
  localparam logic [7:0] OP_AND = 8'hC1;
  localparam logic [7:0] OP_XOR = 8'hC2;
  localparam logic [7:0] OP_OUT = 8'hD0;
  localparam logic [7:0] OP_IN  = 8'hD1;
  localparam logic [7:0] OP_JMP = 8'hE0;
  localparam logic [7:0] OP_JEQ = 8'hE1;
  localparam logic [7:0] OP_CMP = 8'hE2;
  localparam logic [7:0] OP_HLT = 8'hFF;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_OPA,
    ST_OPB,
    ST_EXE,
    ST_INW,
    ST_STOP
  } seq_state_t;

  // number of operand bytes following an opcode
  function automatic logic [1:0] operand_count(input logic [7:0] op);
    case (op)
      OP_MOV, OP_ADD, OP_SUB, OP_OR, OP_AND, OP_XOR, OP_CMP, OP_JEQ: operand_count = 2'd2;
      OP_OUT, OP_IN, OP_JMP:                                       operand_count = 2'd1;
      default:                                                     operand_count = 2'd0;
    endcase
  endfunction

  function automatic logic writes_register(input logic [7:0] op);
    case (op)
      OP_MOV, OP_ADD, OP_SUB, OP_OR, OP_AND, OP_XOR: writes_register = 1'b1;
      default:                                       writes_register = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tiny8_mem.sv
module tiny8_mem #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/tiny8_regfile.sv
module tiny8_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int RSEL = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RSEL-1:0] wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic [RSEL-1:0] rd_idx_a,
  input  logic [RSEL-1:0] rd_idx_b,
  output logic [DW-1:0]   rd_a,
  output logic [DW-1:0]   rd_b
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                regs[g] <= '0;
      else if (wr_en && wr_idx == RSEL'(g))      regs[g] <= wr_data;
    end
  end

  assign rd_a = regs[rd_idx_a];
  assign rd_b = regs[rd_idx_b];

endmodule

// File: rtl/tiny8_alu.sv
module tiny8_alu
  import tiny8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [7:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          eq
);
  always_comb begin
    case (op)
      OP_MOV:  y = b;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      OP_XOR:  y = a ^ b;
      default: y = a;
    endcase
  end

  assign eq = (a == b);

endmodule

// File: rtl/tiny8_ctrl.sv
module tiny8_ctrl
  import tiny8_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int RSEL = 2,
  parameter int HOLD = 2,
  localparam int CW  = $clog2(HOLD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [AW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_data,
  output logic [7:0]      alu_op,
  output logic [RSEL-1:0] sel_a,
  output logic [RSEL-1:0] sel_b,
  input  logic [DW-1:0]   rd_a,
  input  logic [DW-1:0]   alu_y,
  input  logic            alu_eq,
  output logic            wr_en,
  output logic [RSEL-1:0] wr_idx,
  output logic [DW-1:0]   wr_data,
  input  logic [DW-1:0]   in_data,
  input  logic            in_valid,
  output logic            in_ready,
  output logic [DW-1:0]   out_data,
  output logic            out_valid,
  output logic            halted,
  output logic [7:0]      halt_code
);
  seq_state_t st;
  logic [AW-1:0] pc;
  logic [7:0]    opc;
  logic [DW-1:0] opa;
  logic [DW-1:0] opb;
  logic          eq_flag;
  logic [CW-1:0] clr_cnt;
  logic [1:0]    n_ops;

  assign mem_addr = pc;
  assign alu_op   = opc;
  assign sel_a    = opa[RSEL-1:0];
  assign sel_b    = opb[RSEL-1:0];
  assign in_ready = (st == ST_INW);
  assign n_ops    = operand_count(mem_data[7:0]);

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = sel_a;
    wr_data = alu_y;
    if (st == ST_EXE && writes_register(opc)) begin
      wr_en = 1'b1;
    end else if (st == ST_INW && in_valid) begin
      wr_en   = 1'b1;
      wr_data = in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_OPC;
      pc        <= '0;
      opc       <= OP_NOP;
      opa       <= '0;
      opb       <= '0;
      eq_flag   <= 1'b0;
      clr_cnt   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      halted    <= 1'b0;
      halt_code <= 8'h00;
    end else begin
      out_valid <= 1'b0;
      case (st)
        ST_OPC: begin
          opc <= mem_data[7:0];
          pc  <= pc + 1'b1;
          if (clr_cnt != '0) begin
            clr_cnt <= clr_cnt - 1'b1;
            if (clr_cnt == CW'(1)) eq_flag <= 1'b0;
          end
          st <= (n_ops == 2'd0) ? ST_EXE : ST_OPA;
        end
        ST_OPA: begin
          opa <= mem_data;
          pc  <= pc + 1'b1;
          st  <= (operand_count(opc) == 2'd2) ? ST_OPB : ST_EXE;
        end
        ST_OPB: begin
          opb <= mem_data;
          pc  <= pc + 1'b1;
          st  <= ST_EXE;
        end
        ST_EXE: begin
          st <= ST_OPC;
          case (opc)
            OP_NOP, OP_MOV, OP_ADD, OP_SUB, OP_OR, OP_AND, OP_XOR: ;
            OP_CMP: begin
              eq_flag <= alu_eq;
              clr_cnt <= CW'(HOLD);
            end
            OP_JMP: pc <= opa[AW-1:0];
            OP_JEQ: if (eq_flag) pc <= opb[AW-1:0];
            OP_OUT: begin
              out_valid <= 1'b1;
              out_data  <= rd_a;
            end
            OP_IN:  st <= ST_INW;
            default: begin
              halted    <= 1'b1;
              halt_code <= opc;
              st        <= ST_STOP;
            end
          endcase
        end
        ST_INW: if (in_valid) st <= ST_OPC;
        default: st <= ST_STOP;
      endcase
    end
  end

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc)); // R9
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(halt_code))); // R10
  AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready); // R8
  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R7
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eq_flag) |-> $past(st == ST_EXE && opc == OP_CMP)); // R5
  AST_FLAG_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_flag && st == ST_OPC && clr_cnt == CW'(1)) |=> !eq_flag); // R6

endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
  import tiny8_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int NREG = 4,
  parameter int HOLD = 2,
  localparam int RSEL = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          halted,
  output logic [7:0]    halt_code
);
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_data;
  logic [7:0]      alu_op;
  logic [RSEL-1:0] sel_a, sel_b, wr_idx;
  logic [DW-1:0]   rd_a, rd_b, alu_y, wr_data;
  logic            alu_eq, wr_en;

  tiny8_mem #(.DW(DW), .AW(AW)) mem_i (
    .clk(clk), .wr_en(ld_en), .wr_addr(ld_addr), .wr_data(ld_data),
    .rd_addr(mem_addr), .rd_data(mem_data)
  );

  tiny8_regfile #(.DW(DW), .NREG(NREG)) rf_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_a(sel_a), .rd_idx_b(sel_b), .rd_a(rd_a), .rd_b(rd_b)
  );

  tiny8_alu #(.DW(DW)) alu_i (
    .op(alu_op), .a(rd_a), .b(rd_b), .y(alu_y), .eq(alu_eq)
  );

  tiny8_ctrl #(.DW(DW), .AW(AW), .RSEL(RSEL), .HOLD(HOLD)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_data(mem_data),
    .alu_op(alu_op), .sel_a(sel_a), .sel_b(sel_b), .rd_a(rd_a),
    .alu_y(alu_y), .alu_eq(alu_eq), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .halted(halted), .halt_code(halt_code)
  );

endmodule

// File: tb/tiny8_core_tb.sv
module tiny8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_en = 1'b0;
  logic [7:0] ld_addr = '0, ld_data = '0;
  logic [7:0] out_data;
  logic       out_valid;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       halted;
  logic [7:0] halt_code;

  always #2.5 clk = ~clk;

  tiny8_core dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .out_data(out_data), .out_valid(out_valid), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .halted(halted), .halt_code(halt_code)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] prog [256];
  logic [7:0] in_q [8];
  int in_n = 0, in_delay = 0, in_idx = 0, cyc = 0;
  logic [7:0] out_buf [16];
  int out_n = 0;
  int wd = 0;

  // {opcode, x, y, expected}
  localparam logic [31:0] VEC [10] = '{
    {8'hB0, 8'h12, 8'h34, 8'h46}, {8'hB0, 8'hF0, 8'h20, 8'h10},
    {8'hB1, 8'h05, 8'h07, 8'hFE}, {8'hB1, 8'h80, 8'h01, 8'h7F},
    {8'hC0, 8'hA0, 8'h05, 8'hA5}, {8'hC1, 8'hF0, 8'h3C, 8'h30},
    {8'hC2, 8'hFF, 8'h0F, 8'hF0}, {8'hA0, 8'h11, 8'h22, 8'h22},
    {8'hC2, 8'h55, 8'h55, 8'h00}, {8'hB0, 8'hFF, 8'h01, 8'h00}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual expired expected finish");
      summary();
      $finish;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_idx <= 0;
      cyc    <= 0;
    end else begin
      cyc <= cyc + 1;
      if (in_valid && in_ready) in_idx <= in_idx + 1;
    end
  end

  always @(negedge clk) begin
    in_valid = rst_n && (in_idx < in_n) && (cyc >= in_delay);
    in_data  = (in_idx < in_n) ? in_q[in_idx] : 8'h00;
    if (!rst_n) out_n = 0;
    else if (out_valid) begin
      if (out_n < 16) out_buf[out_n] = out_data;
      out_n = out_n + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 8'hFF;
  endtask

  // R12: load through the port while reset is held, then run to halt
  task automatic run(int delay, bit probe);
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      ld_en = 1'b1; ld_addr = 8'(i); ld_data = prog[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    in_delay = delay;
    rst_n = 1'b1;
    if (probe) begin
      repeat (20) @(negedge clk);
      chk("R8 in_ready during stall", in_ready, 1);
      chk("R8 no output during stall", out_n, 0);
    end
    for (int k = 0; k < 3000 && !halted; k++) @(negedge clk);
    if (!halted) chk("R9 reached halt", 0, 1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 halted", halted, 0);
    chk("R1 halt_code", halt_code, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 0);

    // R2 vector table
    for (int v = 0; v < 10; v++) begin
      clear_prog();
      prog[0] = 8'hD1; prog[1] = 8'h00;
      prog[2] = 8'hD1; prog[3] = 8'h01;
      prog[4] = VEC[v][31:24]; prog[5] = 8'h00; prog[6] = 8'h01;
      prog[7] = 8'hD0; prog[8] = 8'h00;
      in_q[0] = VEC[v][23:16]; in_q[1] = VEC[v][15:8]; in_n = 2;
      run(0, 0);
      chk("R2 output count", out_n, 1);
      chk("R2 result", out_buf[0], VEC[v][7:0]);
    end

    // R3 only low two bits select register
    clear_prog();
    prog[0] = 8'hD1; prog[1] = 8'h01;
    prog[2] = 8'hD1; prog[3] = 8'h06;
    prog[4] = 8'hB0; prog[5] = 8'hFD; prog[6] = 8'h0A;
    prog[7] = 8'hD0; prog[8] = 8'h01;
    in_q[0] = 8'h20; in_q[1] = 8'h03; in_n = 2;
    run(0, 0);
    chk("R3 aliased operands", out_buf[0], 8'h23);

    // R1 registers and flag cleared by reset; JEQ not taken without CMP
    clear_prog();
    prog[0] = 8'hE1; prog[1] = 8'h00; prog[2] = 8'h05;
    prog[3] = 8'hD0; prog[4] = 8'h02;
    in_n = 0;
    run(0, 0);
    chk("R1 fall-through count", out_n, 1);
    chk("R1 register zero", out_buf[0], 0);

    // R5 compare then jump-if-equal, equal and unequal
    for (int e = 0; e < 2; e++) begin
      clear_prog();
      prog[0] = 8'hD1; prog[1] = 8'h00;
      prog[2] = 8'hD1; prog[3] = 8'h01;
      prog[4] = 8'hE2; prog[5] = 8'h00; prog[6] = 8'h01;
      prog[7] = 8'hE1; prog[8] = 8'h03; prog[9] = 8'h0C;
      prog[10] = 8'hD0; prog[11] = 8'h00;
      prog[12] = 8'hD0; prog[13] = 8'h01;
      in_q[0] = 8'h05; in_q[1] = (e == 0) ? 8'h05 : 8'h06; in_n = 2;
      run(0, 0);
      chk("R5 branch output count", out_n, (e == 0) ? 1 : 2);
    end

    // R6 flag gone after one intervening instruction
    clear_prog();
    prog[0] = 8'hD1; prog[1] = 8'h00;
    prog[2] = 8'hD1; prog[3] = 8'h01;
    prog[4] = 8'hE2; prog[5] = 8'h00; prog[6] = 8'h01;
    prog[7] = 8'h00;
    prog[8] = 8'hE1; prog[9] = 8'h00; prog[10] = 8'h0D;
    prog[11] = 8'hD0; prog[12] = 8'h00;
    prog[13] = 8'hD0; prog[14] = 8'h01;
    in_q[0] = 8'h07; in_q[1] = 8'h07; in_n = 2;
    run(0, 0);
    chk("R6 stale flag not taken", out_n, 2);

    // R4 unconditional jump skips an output
    clear_prog();
    prog[0] = 8'hD1; prog[1] = 8'h00;
    prog[2] = 8'hE0; prog[3] = 8'h06;
    prog[4] = 8'hD0; prog[5] = 8'h00;
    prog[6] = 8'hD0; prog[7] = 8'h00;
    in_q[0] = 8'h5A; in_n = 1;
    run(0, 0);
    chk("R4 jump output count", out_n, 1);
    chk("R4 jump output value", out_buf[0], 8'h5A);

    // R11 wrap: OUT at 0xFF takes operand from 0x00
    clear_prog();
    prog[0] = 8'h00;
    prog[1] = 8'hD1; prog[2] = 8'h00;
    prog[3] = 8'hE2; prog[4] = 8'h00; prog[5] = 8'h03;
    prog[6] = 8'hE1; prog[7] = 8'h00; prog[8] = 8'h0B;
    prog[9] = 8'hE0; prog[10] = 8'hFF;
    prog[11] = 8'hFF;
    prog[255] = 8'hD0;
    in_q[0] = 8'h09; in_q[1] = 8'h00; in_n = 2;
    run(0, 0);
    chk("R11 wrap output count", out_n, 1);
    chk("R11 wrap output value", out_buf[0], 8'h09);
    chk("R11 halt code", halt_code, 8'hFF);

    // R8 stall with in_valid withheld; R7 single pulse
    clear_prog();
    prog[0] = 8'hD1; prog[1] = 8'h02;
    prog[2] = 8'hD0; prog[3] = 8'h02;
    in_q[0] = 8'hC3; in_n = 1;
    run(30, 1);
    chk("R8 stalled input received", out_buf[0], 8'hC3);
    chk("R7 one strobe per OUT", out_n, 1);

    // R9 halt stops fetching
    clear_prog();
    prog[0] = 8'hD1; prog[1] = 8'h00;
    prog[2] = 8'hD0; prog[3] = 8'h00;
    prog[4] = 8'hFF;
    prog[5] = 8'hD0; prog[6] = 8'h00;
    in_q[0] = 8'h44; in_n = 1;
    run(0, 0);
    repeat (20) @(negedge clk);
    chk("R9 no output after halt", out_n, 1);
    chk("R9 still halted", halted, 1);
    chk("R9 halt code", halt_code, 8'hFF);

    // R10 unknown opcode
    clear_prog();
    prog[0] = 8'hD1; prog[1] = 8'h00;
    prog[2] = 8'hD0; prog[3] = 8'h00;
    prog[4] = 8'h77;
    prog[5] = 8'hD0; prog[6] = 8'h00;
    in_q[0] = 8'h12; in_n = 1;
    run(0, 0);
    chk("R10 halt code", halt_code, 8'h77);
    chk("R10 output count", out_n, 1);

    // R1 reset clears halt state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 halted after reset", halted, 0);
    chk("R1 halt_code after reset", halt_code, 0);

    summary();
    $finish;
  end

endmodule